// File: doc/BRIEF.md
# Dual-Queue DMA Command Scheduler

This block sits between two producers of transfer commands and a single transfer back end. One producer is the local processing element, which issues commands through a channel port; the other is any external agent writing through a memory-mapped proxy port. Each source fills its own command queue. The local queue holds 16 entries and the proxy queue holds 8. Every cycle the scheduler picks at most one eligible command and hands it to the back end. The local queue has fixed priority over the proxy queue.

Each command carries a 5-bit tag. Commands that share a tag form a group for ordering and for completion status. A fenced command waits until all earlier work of its group has completed, and later commands may still pass it. A barrier command holds back itself and every later command of its group until all earlier work of the group has completed. Illegal transfer sizes are refused at the door and flagged.

The back end is modelled by a stub that completes each command after a programmable latency and returns its tag. Per-tag outstanding state then drives a mask-based "all done" query that software can poll.

Top module: `dma_cmd_sched`

## Requirements
- R1: After reset both queues are empty (`loc_free`=16, `prx_free`=8), `iss_valid`=0, `cpl_valid`=0, both error flags are 0, `tag_busy`=0 and `wait_done`=1.
- R2: A legal command is accepted when valid and ready are both high, and the queue's free count drops by one on the next cycle. A port's ready is low only while its queue is full (free count 0) and it offers a legal command.
- R3: A command is illegal when its kind is 3 or its size in bytes is not one of 1, 2, 4, 8 or a non-zero multiple of 16 up to 16384. An illegal command is not queued, its port's ready stays high, and that port's error flag is high for exactly the next cycle.
- R4: When both queues hold an eligible command, the local one is issued (`iss_src`=0). The proxy queue issues (`iss_src`=1) only when the local queue has none.
- R5: Within a queue the oldest eligible command is issued. At most one command issues per cycle. A command accepted at a clock edge can issue in the cycle after that edge. Kind 0 is a plain command.
- R6: A fenced command (kind 1) is not issued while an earlier command with the same tag is still in its queue or any issued command with its tag has not completed. Later commands of that tag may issue before it.
- R7: A barrier command (kind 2) obeys the fence rule. In addition, no later command of the same tag in its queue issues until the barrier itself has issued.
- R8: An issued command completes `lat_cfg` cycles after its issue cycle: `cpl_valid` is high with `cpl_tag` equal to its tag. A `lat_cfg` of 0 acts as 1 and values above 16 act as 16. `lat_cfg` may change only while no command is in flight.
- R9: Bit n of `tag_busy` is set while any command with tag n is queued or issued but not yet completed. `wait_done` is high exactly when no bit set in `wait_mask` (bit n selects tag n) is also set in `tag_busy`.
- R10: The issued command carries its tag, kind, size and direction unchanged. Direction 0 is a get (main storage into local storage) and 1 is a put (local storage to main storage).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lat_cfg | input | 5 | Back-end completion latency in cycles |
| loc_valid | input | 1 | Local channel command valid |
| loc_ready | output | 1 | Local channel can take the command |
| loc_tag | input | 5 | Local command tag |
| loc_kind | input | 2 | Local command kind: 0 plain, 1 fence, 2 barrier, 3 reserved |
| loc_dir | input | 1 | Local command direction: 0 get, 1 put |
| loc_size | input | 15 | Local transfer size in bytes |
| loc_free | output | 5 | Free entries in the local queue |
| loc_err | output | 1 | Local illegal-command pulse |
| prx_valid | input | 1 | Proxy command valid |
| prx_ready | output | 1 | Proxy port can take the command |
| prx_tag | input | 5 | Proxy command tag |
| prx_kind | input | 2 | Proxy command kind |
| prx_dir | input | 1 | Proxy command direction |
| prx_size | input | 15 | Proxy transfer size in bytes |
| prx_free | output | 4 | Free entries in the proxy queue |
| prx_err | output | 1 | Proxy illegal-command pulse |
| iss_valid | output | 1 | A command issues this cycle |
| iss_src | output | 1 | Source of the issued command: 0 local, 1 proxy |
| iss_tag | output | 5 | Issued tag |
| iss_kind | output | 2 | Issued kind |
| iss_dir | output | 1 | Issued direction |
| iss_size | output | 15 | Issued size |
| cpl_valid | output | 1 | Back end completes a command this cycle |
| cpl_tag | output | 5 | Tag of the completing command |
| wait_mask | input | 32 | Tag selection for the wait-all query |
| wait_done | output | 1 | No selected tag has outstanding work |
| tag_busy | output | 32 | Per-tag outstanding flags |

## Verification
The sharpest collision is an issue and a completion landing on the same tag in the same cycle. Here the outstanding count must hold still, and a fence of that tag must stay blocked until the final completion. The bench provokes this with long fence chains on one tag at maximum latency, while both ports push that tag, so acceptances, issues and completions overlap. A second overlap is an acceptance into a queue in the same cycle as an issue from it. This is judged by comparing free counts, the identity of each issued command and `tag_busy` against a behavioural model on every clock.

// File: rtl/dsq_pkg.sv
package dsq_pkg;
    localparam int TAG_W    = 5;
    localparam int NTAGS    = 1 << TAG_W;
    localparam int SIZE_W   = 15;
    localparam int MAX_XFER = 16384;

    typedef enum logic [1:0] {
        CK_PLAIN = 2'd0,
        CK_FENCE = 2'd1,
        CK_BARR  = 2'd2,
        CK_RSVD  = 2'd3
    } kind_e;

    typedef struct packed {
        kind_e              kind;
        logic               dir;
        logic [TAG_W-1:0]   tag;
        logic [SIZE_W-1:0]  size;
    } cmd_t;

    // size in bytes must be 1,2,4,8 or a non-zero multiple of 16 not above MAX_XFER
    function automatic logic cmd_legal(kind_e k, logic [SIZE_W-1:0] s);
        logic small_ok, block_ok;
        small_ok = (s == SIZE_W'(1)) || (s == SIZE_W'(2)) ||
                   (s == SIZE_W'(4)) || (s == SIZE_W'(8));
        block_ok = (s[3:0] == 4'd0) && (s != '0) && (s <= SIZE_W'(MAX_XFER));
        return (small_ok || block_ok) && (k != CK_RSVD);
    endfunction
endpackage

// File: rtl/dsq_queue.sv
module dsq_queue
    import dsq_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  cmd_t             push_cmd,
    input  logic             pop,
    input  logic [NTAGS-1:0] tag_out,
    output logic [CNT_W-1:0] free_cnt,
    output logic             full,
    output logic             has_elig,
    output cmd_t             sel_cmd,
    output logic [NTAGS-1:0] held_tags
);
    typedef struct packed {
        cmd_t [DEPTH-1:0]  ent;
        logic [CNT_W-1:0]  cnt;
    } qst_t;

    qst_t             q_q, q_d;
    logic [DEPTH-1:0] valid_v, blk_v, elig_v;
    logic [IDX_W-1:0] sel_idx;
    logic [CNT_W-1:0] base;

    // per-entry eligibility: ordering against older entries and in-flight work
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            valid_v[i] = (i < int'(q_q.cnt));
            blk_v[i]   = 1'b0;
            for (int j = 0; j < i; j++) begin
                if ((q_q.ent[j].tag == q_q.ent[i].tag) &&
                    ((q_q.ent[j].kind == CK_BARR) || (q_q.ent[i].kind != CK_PLAIN)))
                    blk_v[i] = 1'b1;
            end
            if ((q_q.ent[i].kind != CK_PLAIN) && tag_out[q_q.ent[i].tag])
                blk_v[i] = 1'b1;
            elig_v[i] = valid_v[i] && !blk_v[i];
        end
    end

    // oldest eligible entry wins
    always_comb begin
        sel_idx  = '0;
        has_elig = 1'b0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (elig_v[i]) begin
                sel_idx  = IDX_W'(i);
                has_elig = 1'b1;
            end
        end
        sel_cmd = q_q.ent[sel_idx];
    end

    always_comb begin
        held_tags = '0;
        for (int i = 0; i < DEPTH; i++)
            if (valid_v[i]) held_tags[q_q.ent[i].tag] = 1'b1;
    end

    always_comb begin
        q_d = q_q;
        if (pop) begin
            for (int i = 0; i < DEPTH - 1; i++)
                if (i >= int'(sel_idx)) q_d.ent[i] = q_q.ent[i+1];
        end
        base = q_q.cnt - CNT_W'(pop);
        if (push) begin
            for (int i = 0; i < DEPTH; i++)
                if (i == int'(base)) q_d.ent[i] = push_cmd;
        end
        q_d.cnt = base + CNT_W'(push);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign full     = (q_q.cnt == CNT_W'(DEPTH));
    assign free_cnt = CNT_W'(DEPTH) - q_q.cnt;
endmodule

// File: rtl/dsq_tag_track.sv
module dsq_tag_track
    import dsq_pkg::*;
#(
    parameter  int MAX_OUT = 16,
    localparam int CW      = $clog2(MAX_OUT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic [TAG_W-1:0] inc_tag,
    input  logic             dec,
    input  logic [TAG_W-1:0] dec_tag,
    output logic [NTAGS-1:0] busy
);
    typedef struct packed {
        logic [NTAGS-1:0][CW-1:0] cnt;
    } trk_t;

    trk_t t_q, t_d;

    always_comb begin
        t_d = t_q;
        for (int n = 0; n < NTAGS; n++) begin
            if ((inc && inc_tag == TAG_W'(n)) && !(dec && dec_tag == TAG_W'(n)))
                t_d.cnt[n] = t_q.cnt[n] + CW'(1);
            else if ((dec && dec_tag == TAG_W'(n)) && !(inc && inc_tag == TAG_W'(n)))
                t_d.cnt[n] = t_q.cnt[n] - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    for (genvar n = 0; n < NTAGS; n++) begin : g_busy
        assign busy[n] = |t_q.cnt[n];
    end
endmodule

// File: rtl/dsq_xfer_stub.sv
module dsq_xfer_stub
    import dsq_pkg::*;
#(
    parameter  int MAX_LAT = 16,
    localparam int LAT_W   = $clog2(MAX_LAT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue,
    input  logic [TAG_W-1:0] issue_tag,
    input  logic [LAT_W-1:0] lat,
    output logic             done,
    output logic [TAG_W-1:0] done_tag
);
    typedef struct packed {
        logic             v;
        logic [TAG_W-1:0] tag;
    } slot_t;

    typedef struct packed {
        slot_t [MAX_LAT-1:0] s;
    } stub_t;

    stub_t            st_q, st_d;
    logic [LAT_W-1:0] eff_lat;

    always_comb begin
        if (lat == '0)                      eff_lat = LAT_W'(1);
        else if (lat > LAT_W'(MAX_LAT))     eff_lat = LAT_W'(MAX_LAT);
        else                                eff_lat = lat;

        st_d = st_q;
        for (int i = 0; i < MAX_LAT - 1; i++) st_d.s[i] = st_q.s[i+1];
        st_d.s[MAX_LAT-1] = '0;
        if (issue) begin
            for (int i = 0; i < MAX_LAT; i++)
                if (i == int'(eff_lat) - 1) st_d.s[i] = '{v: 1'b1, tag: issue_tag};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done     = st_q.s[0].v;
    assign done_tag = st_q.s[0].tag;
endmodule

// File: rtl/dma_cmd_sched.sv
module dma_cmd_sched
    import dsq_pkg::*;
#(
    parameter  int LQ_DEPTH = 16,
    parameter  int PQ_DEPTH = 8,
    parameter  int MAX_LAT  = 16,
    localparam int LQ_CW    = $clog2(LQ_DEPTH + 1),
    localparam int PQ_CW    = $clog2(PQ_DEPTH + 1),
    localparam int LAT_W    = $clog2(MAX_LAT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LAT_W-1:0]  lat_cfg,
    input  logic              loc_valid,
    output logic              loc_ready,
    input  logic [TAG_W-1:0]  loc_tag,
    input  logic [1:0]        loc_kind,
    input  logic              loc_dir,
    input  logic [SIZE_W-1:0] loc_size,
    output logic [LQ_CW-1:0]  loc_free,
    output logic              loc_err,
    input  logic              prx_valid,
    output logic              prx_ready,
    input  logic [TAG_W-1:0]  prx_tag,
    input  logic [1:0]        prx_kind,
    input  logic              prx_dir,
    input  logic [SIZE_W-1:0] prx_size,
    output logic [PQ_CW-1:0]  prx_free,
    output logic              prx_err,
    output logic              iss_valid,
    output logic              iss_src,
    output logic [TAG_W-1:0]  iss_tag,
    output logic [1:0]        iss_kind,
    output logic              iss_dir,
    output logic [SIZE_W-1:0] iss_size,
    output logic              cpl_valid,
    output logic [TAG_W-1:0]  cpl_tag,
    input  logic [NTAGS-1:0]  wait_mask,
    output logic              wait_done,
    output logic [NTAGS-1:0]  tag_busy
);
    typedef struct packed {
        logic l;
        logic p;
    } err_t;

    err_t             err_q, err_d;
    cmd_t             l_in, p_in, l_sel, p_sel, win;
    logic             l_legal, p_legal, l_full, p_full;
    logic             l_has, p_has, l_push, p_push;
    logic [NTAGS-1:0] out_busy, l_held, p_held;

    assign l_in = '{kind: kind_e'(loc_kind), dir: loc_dir, tag: loc_tag, size: loc_size};
    assign p_in = '{kind: kind_e'(prx_kind), dir: prx_dir, tag: prx_tag, size: prx_size};

    assign l_legal   = cmd_legal(l_in.kind, l_in.size);
    assign p_legal   = cmd_legal(p_in.kind, p_in.size);
    assign loc_ready = !l_full || !l_legal;
    assign prx_ready = !p_full || !p_legal;
    assign l_push    = loc_valid && l_legal && !l_full;
    assign p_push    = prx_valid && p_legal && !p_full;

    dsq_queue #(.DEPTH(LQ_DEPTH)) u_lq (
        .clk(clk), .rst_n(rst_n), .push(l_push), .push_cmd(l_in), .pop(l_has),
        .tag_out(out_busy), .free_cnt(loc_free), .full(l_full), .has_elig(l_has),
        .sel_cmd(l_sel), .held_tags(l_held)
    );

    dsq_queue #(.DEPTH(PQ_DEPTH)) u_pq (
        .clk(clk), .rst_n(rst_n), .push(p_push), .push_cmd(p_in), .pop(p_has && !l_has),
        .tag_out(out_busy), .free_cnt(prx_free), .full(p_full), .has_elig(p_has),
        .sel_cmd(p_sel), .held_tags(p_held)
    );

    // fixed priority: local channel ahead of proxy
    assign win       = l_has ? l_sel : p_sel;
    assign iss_valid = l_has || p_has;
    assign iss_src   = !l_has;
    assign iss_tag   = win.tag;
    assign iss_kind  = win.kind;
    assign iss_dir   = win.dir;
    assign iss_size  = win.size;

    dsq_xfer_stub #(.MAX_LAT(MAX_LAT)) u_stub (
        .clk(clk), .rst_n(rst_n), .issue(iss_valid), .issue_tag(iss_tag),
        .lat(lat_cfg), .done(cpl_valid), .done_tag(cpl_tag)
    );

    dsq_tag_track #(.MAX_OUT(MAX_LAT)) u_trk (
        .clk(clk), .rst_n(rst_n), .inc(iss_valid), .inc_tag(iss_tag),
        .dec(cpl_valid), .dec_tag(cpl_tag), .busy(out_busy)
    );

    assign tag_busy  = out_busy | l_held | p_held;
    assign wait_done = ~|(tag_busy & wait_mask);

    always_comb begin
        err_d   = err_q;
        err_d.l = loc_valid && !l_legal;
        err_d.p = prx_valid && !p_legal;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) err_q <= '0;
        else        err_q <= err_d;
    end

    assign loc_err = err_q.l;
    assign prx_err = err_q.p;
endmodule

// File: rtl/dsq_sched_chk.sv
module dsq_sched_chk #(
    parameter int LQ_CW = 5,
    parameter int PQ_CW = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             loc_valid,
    input logic             loc_ready,
    input logic [1:0]       loc_kind,
    input logic [14:0]      loc_size,
    input logic [LQ_CW-1:0] loc_free,
    input logic             loc_err,
    input logic             prx_ready,
    input logic [PQ_CW-1:0] prx_free,
    input logic             iss_valid,
    input logic [4:0]       iss_tag,
    input logic [1:0]       iss_kind,
    input logic [14:0]      iss_size,
    input logic [31:0]      tag_busy,
    input logic [31:0]      out_busy
);
    // R2
    loc_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !loc_ready |-> loc_free == '0);

    // R2
    prx_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !prx_ready |-> prx_free == '0);

    // R3
    bad_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        loc_valid && (loc_size == 15'd0 || loc_kind == 2'd3) |-> loc_ready);

    // R3
    bad_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        loc_valid && (loc_size == 15'd0) |=> loc_err);

    // R6
    fence_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid && iss_kind != 2'd0 |-> !out_busy[iss_tag]);

    // R9
    busy_after_iss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |=> tag_busy[$past(iss_tag)]);

    // R10
    legal_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> iss_size != 15'd0 && iss_size <= 15'd16384 && iss_kind != 2'd3);
endmodule

bind dma_cmd_sched dsq_sched_chk #(.LQ_CW(LQ_CW), .PQ_CW(PQ_CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .loc_valid(loc_valid), .loc_ready(loc_ready),
    .loc_kind(loc_kind), .loc_size(loc_size), .loc_free(loc_free), .loc_err(loc_err),
    .prx_ready(prx_ready), .prx_free(prx_free), .iss_valid(iss_valid),
    .iss_tag(iss_tag), .iss_kind(iss_kind), .iss_size(iss_size),
    .tag_busy(tag_busy), .out_busy(out_busy)
);

// File: tb/test_dma_cmd_sched.sv
module test_dma_cmd_sched;
    typedef logic [22:0] cmd_w;  // [22:21] kind, [20] dir, [19:15] tag, [14:0] size

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  lat = 5'd3;
    logic        lv = 0, pv = 0, ld = 0, pd = 0;
    logic [4:0]  lt = 0, pt = 0;
    logic [1:0]  lk = 0, pk = 0;
    logic [14:0] ls = 15'd16, ps = 15'd16;
    logic [31:0] wm = '1;

    logic        loc_ready, loc_err, prx_ready, prx_err;
    logic [4:0]  loc_free;
    logic [3:0]  prx_free;
    logic        iss_valid, iss_src, iss_dir, cpl_valid, wait_done;
    logic [4:0]  iss_tag, cpl_tag;
    logic [1:0]  iss_kind;
    logic [14:0] iss_size;
    logic [31:0] tag_busy;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    cmd_w lq[$], pq[$];
    int   outc[32];
    int   inf_tag[$], inf_rem[$];
    bit   lerr_m = 0, perr_m = 0;

    always #10 clk = ~clk;

    dma_cmd_sched i_dma_cmd_sched (
        .clk(clk), .rst_n(rst_n), .lat_cfg(lat),
        .loc_valid(lv), .loc_ready(loc_ready), .loc_tag(lt), .loc_kind(lk), .loc_dir(ld),
        .loc_size(ls), .loc_free(loc_free), .loc_err(loc_err),
        .prx_valid(pv), .prx_ready(prx_ready), .prx_tag(pt), .prx_kind(pk), .prx_dir(pd),
        .prx_size(ps), .prx_free(prx_free), .prx_err(prx_err),
        .iss_valid(iss_valid), .iss_src(iss_src), .iss_tag(iss_tag), .iss_kind(iss_kind),
        .iss_dir(iss_dir), .iss_size(iss_size), .cpl_valid(cpl_valid), .cpl_tag(cpl_tag),
        .wait_mask(wm), .wait_done(wait_done), .tag_busy(tag_busy)
    );

    task automatic chk(string req, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit legal(logic [1:0] k, logic [14:0] s);
        int v = int'(s);
        if (k == 2'd3) return 0;
        if (v == 1 || v == 2 || v == 4 || v == 8) return 1;
        return (v > 0) && (v % 16 == 0) && (v <= 16384);
    endfunction

    function automatic int pick(cmd_w q[$]);
        for (int i = 0; i < q.size(); i++) begin
            bit blocked = 0;
            for (int j = 0; j < i; j++)
                if (q[j][19:15] == q[i][19:15] && (q[j][22:21] == 2'd2 || q[i][22:21] != 2'd0))
                    blocked = 1;
            if (q[i][22:21] != 2'd0 && outc[q[i][19:15]] > 0) blocked = 1;
            if (!blocked) return i;
        end
        return -1;
    endfunction

    function automatic int eff_lat();
        if (lat == 0) return 1;
        if (lat > 16) return 16;
        return int'(lat);
    endfunction

    // compare this cycle's outputs with the model, then advance the model past the edge
    task automatic tick();
        int   lsel, psel, ctag;
        bit   lok, pok, evalid, esrc;
        cmd_w ec;
        logic [31:0] ebusy;
        string rq;
        #1;
        lsel = pick(lq);
        psel = pick(pq);
        lok  = legal(lk, ls);
        pok  = legal(pk, ps);
        chk("R2", "loc_free", loc_free, 16 - lq.size());
        chk("R2", "prx_free", prx_free, 8 - pq.size());
        chk("R2", "loc_ready", loc_ready, (lq.size() < 16) || !lok);
        chk("R2", "prx_ready", prx_ready, (pq.size() < 8) || !pok);
        chk("R3", "loc_err", loc_err, lerr_m);
        chk("R3", "prx_err", prx_err, perr_m);
        evalid = (lsel >= 0) || (psel >= 0);
        esrc   = (lsel < 0);
        ec     = (lsel >= 0) ? lq[lsel] : ((psel >= 0) ? pq[psel] : '0);
        chk("R5", "iss_valid", iss_valid, evalid);
        if (evalid && iss_valid) begin
            rq = (ec[22:21] == 2'd1) ? "R6" : ((ec[22:21] == 2'd2) ? "R7" : "R5");
            chk("R4", "iss_src", iss_src, esrc);
            chk(rq, "iss_tag", iss_tag, ec[19:15]);
            chk(rq, "iss_kind", iss_kind, ec[22:21]);
            chk("R10", "iss_dir", iss_dir, ec[20]);
            chk("R10", "iss_size", iss_size, ec[14:0]);
        end
        ctag = -1;
        foreach (inf_rem[i]) if (inf_rem[i] == 1) ctag = inf_tag[i];
        chk("R8", "cpl", cpl_valid ? longint'(cpl_tag) : -1, ctag);
        ebusy = '0;
        for (int t = 0; t < 32; t++) if (outc[t] > 0) ebusy[t] = 1;
        foreach (lq[i]) ebusy[lq[i][19:15]] = 1;
        foreach (pq[i]) ebusy[pq[i][19:15]] = 1;
        chk("R9", "tag_busy", tag_busy, ebusy);
        chk("R9", "wait_done", wait_done, (ebusy & wm) == 0);

        // advance model
        for (int i = inf_rem.size() - 1; i >= 0; i--) begin
            if (inf_rem[i] == 1) begin
                outc[inf_tag[i]]--;
                inf_rem.delete(i);
                inf_tag.delete(i);
            end else begin
                inf_rem[i]--;
            end
        end
        if (evalid) begin
            outc[ec[19:15]]++;
            inf_tag.push_back(int'(ec[19:15]));
            inf_rem.push_back(eff_lat());
        end
        if (lsel >= 0) lq.delete(lsel);
        else if (psel >= 0) pq.delete(psel);
        if (lv && lok && (16 - lq.size() + ((lsel >= 0) ? 1 : 0)) > 1 - 1 && lq.size() + ((lsel >= 0) ? 1 : 0) < 16)
            lq.push_back({lk, ld, lt, ls});
        if (pv && pok && pq.size() + ((lsel < 0 && psel >= 0) ? 1 : 0) < 8)
            pq.push_back({pk, pd, pt, ps});
        lerr_m = lv && !lok;
        perr_m = pv && !pok;
        @(negedge clk);
    endtask

    task automatic idle(int n);
        lv = 0; pv = 0;
        repeat (n) tick();
    endtask

    task automatic lcmd(logic [4:0] t, logic [1:0] k, logic d, logic [14:0] s);
        lv = 1; lt = t; lk = k; ld = d; ls = s;
    endtask

    task automatic pcmd(logic [4:0] t, logic [1:0] k, logic d, logic [14:0] s);
        pv = 1; pt = t; pk = k; pd = d; ps = s;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual expired expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int szl[12] = '{1, 2, 4, 8, 16, 48, 16384, 0, 3, 24, 16400, 4096};
        for (int t = 0; t < 32; t++) outc[t] = 0;
        repeat (3) @(negedge clk);
        #1;
        // R1 reset state
        chk("R1", "loc_free", loc_free, 16);
        chk("R1", "prx_free", prx_free, 8);
        chk("R1", "iss_valid", iss_valid, 0);
        chk("R1", "cpl_valid", cpl_valid, 0);
        chk("R1", "errors", {loc_err, prx_err}, 0);
        chk("R1", "tag_busy", tag_busy, 0);
        chk("R1", "wait_done", wait_done, 1);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R5 R10: plain local commands, latency 3
        lat = 3;
        lcmd(1, 0, 0, 16);    tick();
        lcmd(2, 0, 1, 1);     tick();
        lcmd(3, 0, 0, 2);     tick();
        lcmd(4, 0, 1, 4);     tick();
        idle(6);

        // R3: illegal sizes and reserved kind on both ports
        lcmd(1, 0, 0, 3);     tick();
        lcmd(1, 0, 0, 0);     tick();
        lcmd(1, 0, 0, 24);    tick();
        lcmd(1, 0, 0, 16400); tick();
        lcmd(1, 3, 0, 8);     tick();
        lv = 0; pcmd(2, 0, 1, 12); tick();
        idle(3);

        // R4: both ports at once
        lcmd(5, 0, 0, 32); pcmd(6, 0, 1, 64); tick();
        lcmd(5, 0, 1, 8);  pcmd(6, 0, 0, 16384); tick();
        idle(8);

        // R6: fence waits, later same-tag plain overtakes
        lat = 5;
        lcmd(2, 0, 0, 16); tick();
        lcmd(2, 1, 1, 16); tick();
        lcmd(3, 0, 0, 16); tick();
        lcmd(2, 0, 0, 32); tick();
        idle(14);

        // R7: barrier holds later same-tag commands
        pcmd(4, 0, 0, 16); tick();
        pcmd(4, 2, 1, 16); tick();
        pcmd(4, 0, 0, 16); lcmd(4, 0, 1, 8); tick();
        pcmd(5, 0, 0, 16); lv = 0; tick();
        idle(16);

        // R2 R6: fill both queues with fence chains on one tag at max latency
        lat = 16;
        lcmd(1, 0, 0, 16); tick();
        for (int i = 0; i < 22; i++) begin
            lcmd(1, 1, i[0], 32);
            pcmd(1, 1, i[1], 48);
            tick();
        end
        wm = 32'h0000_0002;
        idle(560);

        // R8: latency 0 acts as 1, above 16 acts as 16
        lat = 0;
        lcmd(7, 0, 0, 8); tick();
        lcmd(7, 1, 0, 8); tick();
        idle(4);
        lat = 31;
        pcmd(8, 0, 1, 16); tick();
        idle(20);

        // random traffic on a few tags
        for (int c = 0; c < 4000; c++) begin
            if (inf_tag.size() == 0 && ($urandom % 8) == 0) lat = 5'($urandom % 20);
            wm = (($urandom % 2) == 0) ? (32'h1 << ($urandom % 4)) : 32'($urandom);
            lv = (($urandom % 3) == 0);
            lt = 5'($urandom % 4);
            lk = 2'(($urandom % 8 == 0) ? 3 : ($urandom % 3));
            ld = 1'($urandom % 2);
            ls = 15'(szl[$urandom % 12]);
            pv = (($urandom % 3) == 0);
            pt = 5'($urandom % 4);
            pk = 2'($urandom % 3);
            pd = 1'($urandom % 2);
            ps = 15'(szl[$urandom % 12]);
            tick();
        end
        idle(40);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule